// File: doc/BRIEF.md
# ADC Output Receiver Decoder

This block sits at the receiving end of a high-speed converter's digital output bus. It rebuilds each N-bit sample from either a full-width parallel word or two half-width pieces captured on the rising and falling phases of the converter clock. It then removes the two line encodings the converter may apply to reduce switching noise: inversion of every odd-indexed data line, and XOR scrambling of the upper bits with the least significant bit. Decoded samples leave on a registered bus with a one-cycle valid strobe.

The capture logic in front of the block supplies DDR data as a stream of half-words. Each half-word carries a tag that marks it as the rising-phase or the falling-phase piece. A sample is formed only when a falling piece follows a stored rising piece. Static configuration inputs choose the transfer format and the two decodings. Both decodings may be enabled together. The polarity is restored first, and the restored LSB then drives the descrambling.

Top module: `adc_rx_decoder`

## Requirements
- R1: During and right after reset, `sample_vld_o` is 0 and no rising half-word is held, so in DDR mode a falling half-word that arrives first yields no sample.
- R2: In full-rate mode (`ddr_mode_i`=0), a cycle with `par_vld_i`=1 produces, after the next clock edge, `sample_vld_o`=1 and `sample_o` equal to the decoded `par_data_i` of that cycle.
- R3: In DDR mode, lane k of a rising half-word supplies sample bit 2k+1 and lane k of a falling half-word supplies sample bit 2k. With SAMPLE_W=14 there are 7 lanes.
- R4: In DDR mode, a rising half-word (`half_vld_i`=1, `half_rise_i`=1) produces no output by itself. A later falling half-word (`half_rise_i`=0) produces a sample after the next clock edge, and this clears the held rising half.
- R5: A falling half-word that arrives while no rising half is held is dropped and produces no sample.
- R6: A second rising half-word that arrives before any falling half replaces the first. The next sample uses the newer one.
- R7: Inputs of the inactive format are ignored. Half-words produce nothing in full-rate mode, and `par_vld_i` produces nothing in DDR mode.
- R8: Any cycle in full-rate mode discards a held rising half. After a return to DDR mode, a falling half alone produces no sample.
- R9: With `pol_en_i`=1, every odd-indexed bit of the assembled word is inverted (mask 0x2AAA for 14 bits). Even bits pass unchanged.
- R10: With `rnd_en_i`=1, every bit above bit 0 is XORed with bit 0, taken after the polarity step. Bit 0 itself is never altered.
- R11: For any sample, format and option setting, a word encoded by scrambling (when enabled), then odd-line inversion (when enabled), then transfer in the chosen format, decodes to the original sample.
- R12: `sample_vld_o` is high for exactly one cycle for each reconstructed sample. It stays low in cycles that complete no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ddr_mode_i | input | 1 | 0 = full-rate parallel, 1 = DDR half-words |
| pol_en_i | input | 1 | Undo odd-line inversion |
| rnd_en_i | input | 1 | Undo LSB-XOR scrambling |
| par_data_i | input | SAMPLE_W | Full-rate data word |
| par_vld_i | input | 1 | Full-rate word present this cycle |
| half_data_i | input | SAMPLE_W/2 | DDR half-word, one bit per lane |
| half_rise_i | input | 1 | 1 = rising-phase piece, 0 = falling-phase piece |
| half_vld_i | input | 1 | Half-word present this cycle |
| sample_o | output | SAMPLE_W | Decoded sample |
| sample_vld_o | output | 1 | One-cycle strobe per decoded sample |

## Verification
On every cycle, the assertions check the DDR phase tracker: a rising half arms it, a pairing falling half or any full-rate cycle disarms it, and a falling half with nothing held yields no output. They also check that each valid pulse traces back to a completing input in the previous cycle, that an undecoded full-rate word passes through bit for bit, and that bit 0 survives decoding. The lane-to-bit interleave, the inversion mask, the descrambling order and the full encode/decode round trip for every format and option pair can only be shown by the bench, which compares outputs against its own encoder.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;

    typedef enum logic {
        FMT_FULL = 1'b0,
        FMT_DDR  = 1'b1
    } rx_fmt_e;

    typedef enum logic {
        PH_WAIT_RISE = 1'b0,
        PH_HAVE_RISE = 1'b1
    } ddr_phase_e;

endpackage

// File: rtl/adc_rx_ddr_asm.sv
module adc_rx_ddr_asm
    import adc_rx_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    localparam int LANES = SAMPLE_W / 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ddr_mode_i,
    input  logic [LANES-1:0]    half_data_i,
    input  logic                half_rise_i,
    input  logic                half_vld_i,
    output logic [SAMPLE_W-1:0] word_o,
    output logic                word_stb_o,
    output logic                armed_o
);

    typedef struct packed {
        ddr_phase_e       phase;
        logic [LANES-1:0] rise;
    } asm_state_t;

    asm_state_t st_d, st_q;
    logic [SAMPLE_W-1:0] joined_d;

    // Lane k: rising piece -> bit 2k+1, falling piece -> bit 2k
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign joined_d[2*k+1] = st_q.rise[k];
        assign joined_d[2*k]   = half_data_i[k];
    end

    always_comb begin
        st_d       = st_q;
        word_stb_o = 1'b0;
        word_o     = joined_d;
        if (rx_fmt_e'(ddr_mode_i) == FMT_FULL) begin
            st_d.phase = PH_WAIT_RISE;
        end else if (half_vld_i) begin
            if (half_rise_i) begin
                st_d.rise  = half_data_i;
                st_d.phase = PH_HAVE_RISE;
            end else if (st_q.phase == PH_HAVE_RISE) begin
                word_stb_o = 1'b1;
                st_d.phase = PH_WAIT_RISE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_WAIT_RISE, rise: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o = (st_q.phase == PH_HAVE_RISE);

    p_pair_disarms_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ddr_mode_i && half_vld_i && !half_rise_i && armed_o) |=> !armed_o);

    p_rise_arms_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ddr_mode_i && half_vld_i && half_rise_i)
            |=> (armed_o && st_q.rise == $past(half_data_i)));

    p_full_disarms_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ddr_mode_i |=> !armed_o);

    p_orphan_fall_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (half_vld_i && !half_rise_i && !armed_o) |-> !word_stb_o);

endmodule

// File: rtl/adc_rx_unscramble.sv
module adc_rx_unscramble #(
    parameter int SAMPLE_W = 14
) (
    input  logic                pol_en_i,
    input  logic                rnd_en_i,
    input  logic [SAMPLE_W-1:0] coded_i,
    output logic [SAMPLE_W-1:0] plain_o
);

    logic [SAMPLE_W-1:0] odd_mask;
    logic [SAMPLE_W-1:0] restored;
    logic                lsb_key;

    for (genvar i = 0; i < SAMPLE_W; i++) begin : g_mask
        assign odd_mask[i] = (i % 2 == 1);
    end

    // Step 1: polarity restore; step 2: descramble with restored LSB
    always_comb begin
        restored = pol_en_i ? (coded_i ^ odd_mask) : coded_i;
        lsb_key  = rnd_en_i & restored[0];
        plain_o  = restored ^ {{(SAMPLE_W-1){lsb_key}}, 1'b0};
    end

    always_comb begin
        p_lsb_untouched_r10 : assert (plain_o[0] == coded_i[0]);
    end

endmodule

// File: rtl/adc_rx_decoder.sv
module adc_rx_decoder
    import adc_rx_pkg::*;
#(
    parameter int SAMPLE_W = 14,
    localparam int LANES = SAMPLE_W / 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                ddr_mode_i,
    input  logic                pol_en_i,
    input  logic                rnd_en_i,
    input  logic [SAMPLE_W-1:0] par_data_i,
    input  logic                par_vld_i,
    input  logic [LANES-1:0]    half_data_i,
    input  logic                half_rise_i,
    input  logic                half_vld_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_vld_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
        logic                vld;
    } out_state_t;

    out_state_t          st_d, st_q;
    logic [SAMPLE_W-1:0] ddr_word;
    logic                ddr_stb;
    logic                ddr_armed;
    logic [SAMPLE_W-1:0] raw_word;
    logic                raw_stb;
    logic [SAMPLE_W-1:0] plain_word;

    adc_rx_ddr_asm #(.SAMPLE_W(SAMPLE_W)) u_asm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ddr_mode_i  (ddr_mode_i),
        .half_data_i (half_data_i),
        .half_rise_i (half_rise_i),
        .half_vld_i  (half_vld_i),
        .word_o      (ddr_word),
        .word_stb_o  (ddr_stb),
        .armed_o     (ddr_armed)
    );

    always_comb begin
        if (rx_fmt_e'(ddr_mode_i) == FMT_DDR) begin
            raw_word = ddr_word;
            raw_stb  = ddr_stb;
        end else begin
            raw_word = par_data_i;
            raw_stb  = par_vld_i;
        end
    end

    adc_rx_unscramble #(.SAMPLE_W(SAMPLE_W)) u_unscr (
        .pol_en_i (pol_en_i),
        .rnd_en_i (rnd_en_i),
        .coded_i  (raw_word),
        .plain_o  (plain_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = raw_stb;
        if (raw_stb) begin
            st_d.sample = plain_word;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o     = st_q.sample;
    assign sample_vld_o = st_q.vld;

    p_full_plain_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ddr_mode_i && par_vld_i && !pol_en_i && !rnd_en_i)
            |=> (sample_vld_o && sample_o == $past(par_data_i)));

    p_ddr_ignores_par_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ddr_mode_i && !half_vld_i) |=> !sample_vld_o);

    p_full_ignores_half_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ddr_mode_i && !par_vld_i) |=> !sample_vld_o);

    p_orphan_no_sample_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ddr_mode_i && half_vld_i && !half_rise_i && !ddr_armed) |=> !sample_vld_o);

    p_rise_alone_silent_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ddr_mode_i && half_vld_i && half_rise_i) |=> !sample_vld_o);

endmodule

// File: tb/adc_rx_decoder_tb.sv
module adc_rx_decoder_tb;

    localparam int W = 14;
    localparam int L = W / 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ddr_mode, pol_en, rnd_en;
    logic [W-1:0] par_data;
    logic         par_vld;
    logic [L-1:0] half_data;
    logic         half_rise, half_vld;
    logic [W-1:0] sample;
    logic         sample_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adc_rx_decoder #(.SAMPLE_W(W)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .ddr_mode_i   (ddr_mode),
        .pol_en_i     (pol_en),
        .rnd_en_i     (rnd_en),
        .par_data_i   (par_data),
        .par_vld_i    (par_vld),
        .half_data_i  (half_data),
        .half_rise_i  (half_rise),
        .half_vld_i   (half_vld),
        .sample_o     (sample),
        .sample_vld_o (sample_vld)
    );

    function automatic logic [W-1:0] encode(input logic [W-1:0] v, input logic p, input logic r);
        logic [W-1:0] e = v;
        if (r) for (int i = 1; i < W; i++) e[i] = v[i] ^ v[0];
        if (p) for (int i = 1; i < W; i += 2) e[i] = ~e[i];
        return e;
    endfunction

    function automatic logic [L-1:0] odd_half(input logic [W-1:0] v);
        logic [L-1:0] h;
        for (int k = 0; k < L; k++) h[k] = v[2*k+1];
        return h;
    endfunction

    function automatic logic [L-1:0] even_half(input logic [W-1:0] v);
        logic [L-1:0] h;
        for (int k = 0; k < L; k++) h[k] = v[2*k];
        return h;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // All drive tasks start and end at a falling edge; outputs then show the last posedge.
    task automatic put_par(input logic [W-1:0] d);
        par_data = d; par_vld = 1'b1;
        @(negedge clk);
        par_vld = 1'b0;
    endtask

    task automatic put_half(input logic [L-1:0] d, input logic rise);
        half_data = d; half_rise = rise; half_vld = 1'b1;
        @(negedge clk);
        half_vld = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic full_xfer(input string req, input logic [W-1:0] raw, input logic [W-1:0] exp);
        put_par(raw);
        chk({req, " vld"}, W'(sample_vld), W'(1));
        chk({req, " data"}, sample, exp);
        idle();
        chk({req, " R12 pulse ends"}, W'(sample_vld), W'(0));
    endtask

    task automatic ddr_xfer(input string req, input logic [W-1:0] raw, input logic [W-1:0] exp);
        put_half(odd_half(raw), 1'b1);
        chk({req, " R4 rise silent"}, W'(sample_vld), W'(0));
        put_half(even_half(raw), 1'b0);
        chk({req, " vld"}, W'(sample_vld), W'(1));
        chk({req, " data"}, sample, exp);
        idle();
        chk({req, " R12 pulse ends"}, W'(sample_vld), W'(0));
    endtask

    task automatic t_reset();
        ddr_mode = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 vld in reset", W'(sample_vld), W'(0));
        rst_n = 1'b1;
        idle();
        chk("R1 vld after reset", W'(sample_vld), W'(0));
        put_half(7'h55, 1'b0);
        chk("R1 fall before any rise", W'(sample_vld), W'(0));
    endtask

    task automatic t_full_basic();
        ddr_mode = 1'b0; pol_en = 1'b0; rnd_en = 1'b0;
        full_xfer("R2 plain a", 14'h1234, 14'h1234);
        full_xfer("R2 plain b", 14'h3FFF, 14'h3FFF);
        put_par(14'h0AAA);
        put_par(14'h1555);
        chk("R12 back-to-back vld", W'(sample_vld), W'(1));
        chk("R2 back-to-back data", sample, 14'h1555);
        idle();
    endtask

    task automatic t_options();
        ddr_mode = 1'b0;
        pol_en = 1'b1; rnd_en = 1'b0;
        full_xfer("R9 polarity zero", 14'h0000, 14'h2AAA);
        full_xfer("R9 polarity ones", 14'h3FFF, 14'h1555);
        pol_en = 1'b0; rnd_en = 1'b1;
        full_xfer("R10 derand lsb1", 14'h0001, 14'h3FFF);
        full_xfer("R10 derand lsb0", 14'h2AAA, 14'h2AAA);
        pol_en = 1'b1; rnd_en = 1'b1;
        full_xfer("R11 order lsb1", 14'h0001, 14'h1555);
        full_xfer("R11 order lsb0", 14'h0000, 14'h2AAA);
        pol_en = 1'b0; rnd_en = 1'b0;
    endtask

    task automatic t_ddr_map();
        ddr_mode = 1'b1;
        put_half(7'h7F, 1'b1);
        put_half(7'h00, 1'b0);
        chk("R3 rise lanes odd bits", sample, 14'h2AAA);
        idle();
        put_half(7'h00, 1'b1);
        put_half(7'h7F, 1'b0);
        chk("R3 fall lanes even bits", sample, 14'h1555);
        idle();
        ddr_xfer("R4 ddr word", 14'h2C71, 14'h2C71);
    endtask

    task automatic t_orphan();
        ddr_mode = 1'b1;
        ddr_xfer("R5 setup", 14'h0F0F, 14'h0F0F);
        put_half(7'h3C, 1'b0);
        chk("R5 orphan fall", W'(sample_vld), W'(0));
        chk("R5 output kept", sample, 14'h0F0F);
    endtask

    task automatic t_replace();
        ddr_mode = 1'b1;
        put_half(7'h00, 1'b1);
        put_half(7'h7F, 1'b1);
        put_half(7'h00, 1'b0);
        chk("R6 newer rise vld", W'(sample_vld), W'(1));
        chk("R6 newer rise used", sample, 14'h2AAA);
        idle();
    endtask

    task automatic t_ignore();
        ddr_mode = 1'b0;
        put_half(7'h7F, 1'b1);
        put_half(7'h7F, 1'b0);
        chk("R7 halves ignored in full", W'(sample_vld), W'(0));
        ddr_mode = 1'b1;
        put_par(14'h3333);
        chk("R7 par ignored in ddr", W'(sample_vld), W'(0));
        put_half(7'h01, 1'b0);
        chk("R7 no pending from full", W'(sample_vld), W'(0));
    endtask

    task automatic t_mode_clear();
        ddr_mode = 1'b1;
        put_half(7'h12, 1'b1);
        ddr_mode = 1'b0;
        idle();
        ddr_mode = 1'b1;
        put_half(7'h34, 1'b0);
        chk("R8 rise dropped by full cycle", W'(sample_vld), W'(0));
    endtask

    task automatic t_roundtrip();
        logic [W-1:0] v = 14'h1ACE;
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 4; o++) begin
                ddr_mode = m[0]; pol_en = o[1]; rnd_en = o[0];
                for (int n = 0; n < 6; n++) begin
                    v = {v[W-2:0], v[W-1] ^ v[W-3] ^ v[3] ^ v[0]};
                    if (n == 0) v[0] = 1'b1;
                    if (m == 0) full_xfer("R11 roundtrip full", encode(v, o[1], o[0]), v);
                    else        ddr_xfer("R11 roundtrip ddr", encode(v, o[1], o[0]), v);
                end
            end
        end
        pol_en = 1'b0; rnd_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; ddr_mode = 1'b0; pol_en = 1'b0; rnd_en = 1'b0;
        par_data = '0; par_vld = 1'b0;
        half_data = '0; half_rise = 1'b0; half_vld = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_basic();
        t_options();
        t_ddr_map();
        t_orphan();
        t_replace();
        t_ignore();
        t_mode_clear();
        t_roundtrip();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule